// File: doc/BRIEF.md
# Cascadable LCD Segment Line Loader

The block collects one display line of pixel data for a segment driver. Bytes or nibbles arrive on a parallel bus, one per data clock. They are packed into a staging latch of 240 bits, organised as 30 groups of 8 bits. A fill direction input selects which end of the output row is written first. The two enable pins swap their roles as enable-in and enable-out with that direction.

Several loaders can be chained. A loader captures data only while its enable-in is high. After its 30th group is written it stops capturing and raises enable-out, which selects the next loader in the chain. A rising edge on the line pulse copies the staging latch into the line latch, which drives the segment bits. The same edge clears the fill state. While the active-low display-off input is low, the line latch is held at zero.

All inputs are synchronous to `clk_i`, which is the data clock. The line pulse is edge-detected in that clock domain.

Top module: `seg_loader`

## Requirements
- R1: After reset, `seg_o` is all zeros and both `eio_a_o` and `eio_b_o` are low.
- R2: With `wide_i`=1, every selected clock captures `data_i[7:0]` as one whole group, so 30 selected clocks fill the staging latch.
- R3: With `wide_i`=0, two selected clocks build one group. The first nibble (`data_i[3:0]`) goes to group bits [3:0] and the second to bits [7:4], so 60 selected clocks fill the staging latch.
- R4: With `dir_i`=0, the k-th group written (k from 0) lands in `seg_o[8k+7:8k]`, enable-in is `eio_a_i` and enable-out is driven on `eio_b_o`, with `eio_a_o` held low. With `dir_i`=1, the k-th group lands in `seg_o[8(29-k)+7:8(29-k)]`, enable-in is `eio_b_i` and enable-out is driven on `eio_a_o`, with `eio_b_o` held low.
- R5: A clock on which enable-in is low captures nothing and does not advance the fill position.
- R6: Once the 30th group has been written, further clocks capture nothing until the next line pulse rising edge.
- R7: Enable-out rises on the clock edge after the edge that writes the 30th group, and it stays high until a line pulse rising edge.
- R8: On a rising edge of `lp_i`, the staging content goes to `seg_o`, the fill position returns to group 0 and enable-out falls. The staging latch keeps its content. Holding `lp_i` high does not transfer again.
- R9: While `dispoff_ni` is low, `seg_o` is cleared to zero at each clock edge, and this takes priority over a line pulse transfer.
- R10: A data capture that coincides with a line pulse rising edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: 8-bit bus, 0: 4-bit bus |
| dir_i | input | 1 | Fill direction and enable pin roles |
| data_i | input | 8 | Parallel pixel data |
| lp_i | input | 1 | Line pulse, transfers on its rising edge |
| dispoff_ni | input | 1 | Display off, active low |
| eio_a_i | input | 1 | Enable-in when dir_i=0 |
| eio_b_i | input | 1 | Enable-in when dir_i=1 |
| eio_a_o | output | 1 | Enable-out when dir_i=1, low otherwise |
| eio_b_o | output | 1 | Enable-out when dir_i=0, low otherwise |
| seg_o | output | 240 | Line latch bits |

## Verification
Two events can fall in the same clock. One pair is a line pulse rising edge and a selected data capture, including the capture of the last group. The other pair is a display-off and a line pulse. The bench provokes both by raising `lp_i` while enable-in is high in the middle of a fill, and by holding `dispoff_ni` low across a line pulse edge. A reference model steps each clock and gives the line pulse priority over capture, and display-off priority over transfer. Every segment bit and both enable outputs are compared against it after each edge.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } fill_dir_e;
endpackage

// File: rtl/seg_lp_edge.sv
module seg_lp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_i,
  output logic rise_o
);
  logic lp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_q <= 1'b0;
    else         lp_q <= lp_i;
  end

  assign rise_o = lp_i & ~lp_q;

  AST_LP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R8
endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl
  import seg_loader_pkg::*;
#(
  parameter int unsigned GROUPS = 30,
  parameter int unsigned GRP_W  = 8,
  localparam int unsigned CNT_W = $clog2(GROUPS),
  localparam int unsigned NIB_W = GRP_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  fill_dir_e        dir_i,
  input  logic [GRP_W-1:0] data_i,
  input  logic             en_in_i,
  input  logic             lp_rise_i,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] wr_slot_o,
  output logic [GRP_W-1:0] wr_data_o,
  output logic             full_o,
  output logic             en_out_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             half_q;
  logic [NIB_W-1:0] nib_q;
  logic             full_q, en_out_q;
  logic             cap, last;

  assign cap  = en_in_i & ~full_q & ~lp_rise_i;  // line pulse wins
  assign last = (cnt_q == CNT_W'(GROUPS - 1));

  assign wr_en_o   = cap & (wide_i | half_q);
  assign wr_data_o = wide_i ? data_i : {data_i[NIB_W-1:0], nib_q};
  assign wr_slot_o = (dir_i == DIR_REV) ? (CNT_W'(GROUPS - 1) - cnt_q) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      half_q   <= 1'b0;
      nib_q    <= '0;
      full_q   <= 1'b0;
      en_out_q <= 1'b0;
    end else if (lp_rise_i) begin
      cnt_q    <= '0;
      half_q   <= 1'b0;
      full_q   <= 1'b0;
      en_out_q <= 1'b0;
    end else begin
      en_out_q <= full_q;
      if (cap && !wide_i && !half_q) begin
        nib_q  <= data_i[NIB_W-1:0];
        half_q <= 1'b1;
      end
      if (wr_en_o) begin
        half_q <= 1'b0;
        if (last) full_q <= 1'b1;
        else      cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign full_o   = full_q;
  assign en_out_o = en_out_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(GROUPS - 1)); // R2
  AST_EN_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_out_q) |-> $past(full_q)); // R7
  AST_LP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_rise_i |=> (!full_q && !en_out_q && cnt_q == '0)); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !lp_rise_i) |=> full_q); // R6
endmodule

// File: rtl/seg_stage.sv
module seg_stage #(
  parameter int unsigned GROUPS = 30,
  parameter int unsigned GRP_W  = 8,
  localparam int unsigned CNT_W = $clog2(GROUPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [CNT_W-1:0]        wr_slot_i,
  input  logic [GRP_W-1:0]        wr_data_i,
  output logic [GROUPS*GRP_W-1:0] stage_o
);
  logic [GROUPS-1:0][GRP_W-1:0] grp_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      grp_q[g] <= '0;
      else if (wr_en_i && wr_slot_i == CNT_W'(g))       grp_q[g] <= wr_data_i;
    end
  end

  assign stage_o = grp_q;

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(stage_o)); // R5
endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch #(
  parameter int unsigned WIDTH = 240
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dispoff_ni,
  input  logic             lp_rise_i,
  input  logic [WIDTH-1:0] stage_i,
  output logic [WIDTH-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         line_o <= '0;
    else if (!dispoff_ni) line_o <= '0;
    else if (lp_rise_i)  line_o <= stage_i;
  end

  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dispoff_ni |=> (line_o == '0)); // R9
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispoff_ni && !lp_rise_i) |=> $stable(line_o)); // R8
  AST_LINE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispoff_ni && lp_rise_i) |=> (line_o == $past(stage_i))); // R8
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_loader_pkg::*;
#(
  parameter int unsigned OUTS  = 240,
  parameter int unsigned GRP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wide_i,
  input  logic            dir_i,
  input  logic [GRP_W-1:0] data_i,
  input  logic            lp_i,
  input  logic            dispoff_ni,
  input  logic            eio_a_i,
  input  logic            eio_b_i,
  output logic            eio_a_o,
  output logic            eio_b_o,
  output logic [OUTS-1:0] seg_o
);
  localparam int unsigned GROUPS = OUTS / GRP_W;
  localparam int unsigned CNT_W  = $clog2(GROUPS);

  fill_dir_e        dir;
  logic             en_in, en_out, full, lp_rise, wr_en;
  logic [CNT_W-1:0] wr_slot;
  logic [GRP_W-1:0] wr_data;
  logic [OUTS-1:0]  stage;

  assign dir   = fill_dir_e'(dir_i);
  assign en_in = (dir == DIR_REV) ? eio_b_i : eio_a_i;

  assign eio_b_o = (dir == DIR_FWD) & en_out;
  assign eio_a_o = (dir == DIR_REV) & en_out;

  seg_lp_edge u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lp_i(lp_i), .rise_o(lp_rise)
  );

  seg_fill_ctrl #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wide_i   (wide_i),
    .dir_i    (dir),
    .data_i   (data_i),
    .en_in_i  (en_in),
    .lp_rise_i(lp_rise),
    .wr_en_o  (wr_en),
    .wr_slot_o(wr_slot),
    .wr_data_o(wr_data),
    .full_o   (full),
    .en_out_o (en_out)
  );

  seg_stage #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_slot_i(wr_slot),
    .wr_data_i(wr_data),
    .stage_o  (stage)
  );

  seg_line_latch #(.WIDTH(OUTS)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dispoff_ni(dispoff_ni),
    .lp_rise_i (lp_rise),
    .stage_i   (stage),
    .line_o    (seg_o)
  );

  AST_FULL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !lp_rise) |=> $stable(stage)); // R6
  AST_LP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_rise |=> !(eio_a_o || eio_b_o)); // R8
  AST_ONE_ENOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eio_a_o && eio_b_o)); // R4
endmodule

// File: tb/seg_loader_tb.sv
`timescale 1ns/1ps
module seg_loader_tb;
  localparam int OUTS = 240;
  localparam int GROUPS = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide, dir, lp, doff_n, ea_i, eb_i, ea_o, eb_o;
  logic [7:0] data;
  logic [OUTS-1:0] seg;

  int n_tests = 0, n_fail = 0;

  // reference model state
  logic [OUTS-1:0] m_stage, m_line;
  int   m_cnt;
  logic m_half, m_full, m_en, m_lpq;
  logic [3:0] m_nib;

  always #2.5 clk = ~clk;

  seg_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .dir_i(dir), .data_i(data),
    .lp_i(lp), .dispoff_ni(doff_n), .eio_a_i(ea_i), .eio_b_i(eb_i),
    .eio_a_o(ea_o), .eio_b_o(eb_o), .seg_o(seg)
  );

  task automatic check(input string req);
    logic exp_a, exp_b;
    exp_a = dir & m_en;
    exp_b = ~dir & m_en;
    n_tests++;
    if (seg !== m_line || ea_o !== exp_a || eb_o !== exp_b) begin
      n_fail++;
      $display("FAIL %s: seg=%h eio_a=%b eio_b=%b expected seg=%h eio_a=%b eio_b=%b",
               req, seg, ea_o, eb_o, m_line, exp_a, exp_b);
    end
  endtask

  // one data clock: drive at negedge, update model at posedge, compare after
  task automatic step(input logic en, input logic [7:0] d, input logic l,
                      input logic off_n, input string req);
    logic lr, cap, wr;
    logic [7:0] byte_v;
    int slot;
    @(negedge clk);
    data = d; lp = l; doff_n = off_n;
    ea_i = dir ? 1'b0 : en;
    eb_i = dir ? en : 1'b0;
    @(posedge clk);
    #1;
    lr  = l & ~m_lpq;
    cap = en & ~m_full & ~lr;
    wr  = cap & (wide | m_half);
    byte_v = wide ? d : {d[3:0], m_nib};
    slot = dir ? (GROUPS - 1 - m_cnt) : m_cnt;
    if (!off_n)  m_line = '0;
    else if (lr) m_line = m_stage;
    if (lr) begin
      m_cnt = 0; m_half = 0; m_full = 0; m_en = 0;
    end else begin
      m_en = m_full;
      if (cap && !wide && !m_half) begin m_nib = d[3:0]; m_half = 1; end
      if (wr) begin
        m_stage[slot*8 +: 8] = byte_v;
        m_half = 0;
        if (m_cnt == GROUPS - 1) m_full = 1;
        else m_cnt++;
      end
    end
    m_lpq = l;
    check(req);
  endtask

  task automatic fill_line(input logic w, input logic dr, input string req);
    int guard = 0;
    @(negedge clk);
    wide = w; dir = dr;
    while (!m_en && guard < 400) begin
      step(($urandom % 4) != 0, 8'($urandom), 1'b0, 1'b1, req);
      guard++;
    end
    for (int i = 0; i < 5; i++) step(1'b1, 8'($urandom), 1'b0, 1'b1, "R6");
    step(1'b1, 8'($urandom), 1'b1, 1'b1, "R8");
    step(1'b1, 8'($urandom), 1'b1, 1'b1, "R8");  // held high: no second transfer
    step(1'b0, 8'h00, 1'b0, 1'b1, "R8");
  endtask

  initial begin
    void'($urandom(32'd1234));
    wide = 1; dir = 0; lp = 0; doff_n = 1; ea_i = 0; eb_i = 0; data = 0;
    m_stage = '0; m_line = '0; m_cnt = 0; m_half = 0; m_full = 0; m_en = 0;
    m_lpq = 0; m_nib = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    @(negedge clk); rst_n = 1;
    check("R1");

    fill_line(1'b1, 1'b0, "R2");
    fill_line(1'b0, 1'b0, "R3");
    fill_line(1'b1, 1'b1, "R4");
    fill_line(1'b0, 1'b1, "R4");

    // R5: enable-in low, nothing captured, then a transfer shows stage unchanged
    wide = 1; dir = 0;
    for (int i = 0; i < 8; i++) step(1'b0, 8'($urandom), 1'b0, 1'b1, "R5");
    step(1'b0, 8'h00, 1'b1, 1'b1, "R5");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R5");

    // R10: line pulse edge together with selected data
    for (int i = 0; i < 4; i++) step(1'b1, 8'($urandom), 1'b0, 1'b1, "R10");
    step(1'b1, 8'hA5, 1'b1, 1'b1, "R10");
    step(1'b1, 8'h3C, 1'b0, 1'b1, "R10");
    step(1'b0, 8'h00, 1'b1, 1'b1, "R10");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R10");

    // R10: line pulse exactly on the last group write
    while (m_cnt != GROUPS - 1) step(1'b1, 8'($urandom), 1'b0, 1'b1, "R7");
    step(1'b1, 8'hEE, 1'b1, 1'b1, "R10");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R10");

    // R7: enable-out timing, R9: display off wins over line pulse
    while (!m_full) step(1'b1, 8'($urandom), 1'b0, 1'b1, "R7");
    step(1'b1, 8'h11, 1'b0, 1'b1, "R7");
    step(1'b0, 8'h00, 1'b1, 1'b0, "R9");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R9");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R9");
    step(1'b0, 8'h00, 1'b1, 1'b1, "R8");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R9");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule